// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Almost Flags

This block is a first-in first-out buffer that moves 9-bit words from a write clock domain to an independent read clock domain. The write side stores a word when two write enables agree (one active-low, one active-high) and the buffer has room. The read side takes a word when both active-low read enables are asserted and the buffer holds data. A popped word is loaded into an output register, which drives the data bus unless the output enable is high.

Four active-low status flags report occupancy. Empty and almost-empty belong to the read clock. Full and almost-full belong to the write clock. The two almost thresholds come from offset inputs, `n` on the empty side and `m` on the full side. A separate configuration block drives these offsets and loads 7 into each after reset.

The pointers cross between domains as Gray code through multi-flop synchronizers. Each flag therefore sees the far pointer late. The flags can report less room or less data than is really there, but never more.

Top module: `dcf_fifo`

## Requirements
- R1: A word is stored on a rising `wr_clk` edge only when `wr_en1_n`=0, `wr_en2`=1 and `full_n`=1. A write attempt while `full_n`=0 is dropped and never appears at the read port.
- R2: A word is popped on a rising `rd_clk` edge only when `rd_en1_n`=0, `rd_en2_n`=0 and `empty_n`=1. A read attempt while `empty_n`=0 changes nothing.
- R3: `empty_n` and `aempty_n` change only on `rd_clk` edges. `full_n` and `afull_n` change only on `wr_clk` edges.
- R4: `aempty_n` is 0 when the buffer holds `empty_ofs` words or fewer, and 1 when it holds `empty_ofs`+1 words or more. `empty_n` is 0 exactly when the buffer holds no words.
- R5: `afull_n` is 0 when the number of free locations is `full_ofs` or fewer (that is, occupancy is at least DEPTH−`full_ofs`), and 1 otherwise. `full_n` is 0 exactly when occupancy equals DEPTH.
- R6: Words leave the read port in the order in which they were stored.
- R7: The output register changes only on a pop. After the buffer drains, it keeps the last word that was read.
- R8: While `rst_n`=0 at a clock edge, that domain returns to the empty state. On the read side `empty_n`=0, `aempty_n`=0 and the output register is 0. On the write side `full_n`=1 and `afull_n`=1.
- R9: After a write into an empty buffer, the data bus keeps its old value until `empty_n` rises. The stored word appears after the first pop edge that follows.
- R10: With `out_en_n`=1, `rd_data` is high impedance. With `out_en_n`=0, it shows the output register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-domain clock |
| rd_clk | input | 1 | Read-domain clock |
| rst_n | input | 1 | Active-low reset, sampled synchronously in each domain |
| wr_en1_n | input | 1 | Active-low write enable |
| wr_en2 | input | 1 | Active-high write enable |
| wr_data | input | 9 | Word to store |
| rd_en1_n | input | 1 | Active-low read enable |
| rd_en2_n | input | 1 | Active-low read enable |
| out_en_n | input | 1 | Active-low output enable for `rd_data` |
| empty_ofs | input | log2(DEPTH) | Almost-empty offset n |
| full_ofs | input | log2(DEPTH) | Almost-full offset m |
| rd_data | output | 9 | Output register value, or high impedance |
| empty_n | output | 1 | Low when empty (read domain) |
| aempty_n | output | 1 | Low when almost empty (read domain) |
| full_n | output | 1 | Low when full (write domain) |
| afull_n | output | 1 | Low when almost full (write domain) |

## Verification
The bench builds the block with DEPTH=16 and two synchronizer stages, and drives offsets n=3 and m=2. With these values, the full boundary, the overflow attempt and both almost thresholds each take only a handful of writes. The bench can stop either clock on its own. While one clock is stopped, it checks that the flags owned by that clock hold, even though the other domain has moved its pointer. It then drains the buffer completely, which confirms the ordering and shows that the dropped overflow word never appears.

// File: rtl/dcf_pkg.sv
// Shared defaults for the dual-clock FIFO.
// Assumes: nothing; constants only.
package dcf_pkg;
    localparam int DCF_DATA_W_DEF = 9;
    localparam int DCF_DEPTH_DEF  = 256;
    localparam int DCF_SYNC_DEF   = 2;
endpackage

// File: rtl/dcf_ram.sv
// Storage array: one synchronous write port and one combinational read port.
// Assumes: write and read use different clocks; the read address is stable
// whenever the read side samples the data.
module dcf_ram #(
    parameter int DATA_W = 9,
    parameter int ADDR_W = 8
) (
    input  logic              wr_clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    // Store the incoming word at the write address.
    always_ff @(posedge wr_clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    // Present the word at the read address.
    assign rdata = mem[raddr];
endmodule

// File: rtl/dcf_sync.sv
// Multi-flop synchronizer for a Gray-coded pointer.
// Assumes: only one bit of d changes between successive values.
module dcf_sync #(
    parameter int W      = 9,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage [STAGES];

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            // Shift the pointer one flop further into this domain.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    stage[g] <= '0;
                end else if (g == 0) begin
                    stage[g] <= d;
                end else begin
                    stage[g] <= stage[(g == 0) ? 0 : g-1];
                end
            end
        end
    endgenerate

    assign q = stage[STAGES-1];
endmodule

// File: rtl/dcf_wr_ctrl.sv
// Write side: write pointer, Gray export, full and almost-full flags.
// Assumes: rgray_async is a Gray pointer from the read domain; flags are
// owned by wr_clk and can only err toward reporting less room.
module dcf_wr_ctrl #(
    parameter int ADDR_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              wr_clk,
    input  logic              rst_n,
    input  logic              wr_en1_n,
    input  logic              wr_en2,
    input  logic [ADDR_W-1:0] full_ofs,
    input  logic [ADDR_W:0]   rgray_async,
    output logic              wr_ok,
    output logic [ADDR_W-1:0] waddr,
    output logic [ADDR_W:0]   wgray,
    output logic              full_n,
    output logic              afull_n
);
    localparam int PW = ADDR_W + 1;
    localparam logic [PW-1:0] DEPTH_P = PW'(1) << ADDR_W;

    logic [PW-1:0] rgray_s, rbin, wbin, wbin_next, count_next, free_next;

    dcf_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_rsync (
        .clk   (wr_clk),
        .rst_n (rst_n),
        .d     (rgray_async),
        .q     (rgray_s)
    );

    // Convert the synchronized read pointer back to binary.
    always_comb begin
        for (int i = 0; i < PW; i++) begin
            rbin[i] = ^(rgray_s >> i);
        end
    end

    assign wr_ok      = !wr_en1_n && wr_en2 && full_n;
    assign wbin_next  = wbin + PW'(wr_ok);
    assign count_next = wbin_next - rbin;
    assign free_next  = DEPTH_P - count_next;
    assign waddr      = wbin[ADDR_W-1:0];

    // Advance the write pointer and register the write-domain flags.
    always_ff @(posedge wr_clk) begin
        if (!rst_n) begin
            wbin    <= '0;
            wgray   <= '0;
            full_n  <= 1'b1;
            afull_n <= 1'b1;
        end else begin
            wbin    <= wbin_next;
            wgray   <= wbin_next ^ (wbin_next >> 1);
            full_n  <= (count_next != DEPTH_P);
            afull_n <= (free_next > {1'b0, full_ofs});
        end
    end

    // R1: a full buffer never advances the write pointer
    assert_no_overflow_R1: assert property (@(posedge wr_clk) disable iff (!rst_n)
        !full_n |=> (wbin == $past(wbin)));
    // R5: occupancy seen from the write side never exceeds the depth
    assert_occupancy_bound_R5: assert property (@(posedge wr_clk) disable iff (!rst_n)
        (PW'(wbin - rbin) <= DEPTH_P));
    // R5: full always implies almost full
    assert_full_in_afull_R5: assert property (@(posedge wr_clk) disable iff (!rst_n)
        !full_n |-> !afull_n);
endmodule

// File: rtl/dcf_rd_ctrl.sv
// Read side: read pointer, Gray export, empty and almost-empty flags, and
// the output register that holds the last popped word.
// Assumes: wgray_async is a Gray pointer from the write domain; flags are
// owned by rd_clk and can only err toward reporting less data.
module dcf_rd_ctrl #(
    parameter int DATA_W      = 9,
    parameter int ADDR_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              rd_clk,
    input  logic              rst_n,
    input  logic              rd_en1_n,
    input  logic              rd_en2_n,
    input  logic [ADDR_W-1:0] empty_ofs,
    input  logic [ADDR_W:0]   wgray_async,
    input  logic [DATA_W-1:0] rdata,
    output logic [ADDR_W-1:0] raddr,
    output logic [ADDR_W:0]   rgray,
    output logic [DATA_W-1:0] q,
    output logic              empty_n,
    output logic              aempty_n
);
    localparam int PW = ADDR_W + 1;

    logic [PW-1:0] wgray_s, wbin, rbin, rbin_next, count_next;
    logic          rd_ok;

    dcf_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_wsync (
        .clk   (rd_clk),
        .rst_n (rst_n),
        .d     (wgray_async),
        .q     (wgray_s)
    );

    // Convert the synchronized write pointer back to binary.
    always_comb begin
        for (int i = 0; i < PW; i++) begin
            wbin[i] = ^(wgray_s >> i);
        end
    end

    assign rd_ok      = !rd_en1_n && !rd_en2_n && empty_n;
    assign rbin_next  = rbin + PW'(rd_ok);
    assign count_next = wbin - rbin_next;
    assign raddr      = rbin[ADDR_W-1:0];

    // Advance the read pointer, register the read-domain flags.
    always_ff @(posedge rd_clk) begin
        if (!rst_n) begin
            rbin     <= '0;
            rgray    <= '0;
            empty_n  <= 1'b0;
            aempty_n <= 1'b0;
        end else begin
            rbin     <= rbin_next;
            rgray    <= rbin_next ^ (rbin_next >> 1);
            empty_n  <= (count_next != '0);
            aempty_n <= (count_next > {1'b0, empty_ofs});
        end
    end

    // Load the popped word; hold it otherwise.
    always_ff @(posedge rd_clk) begin
        if (!rst_n) begin
            q <= '0;
        end else if (rd_ok) begin
            q <= rdata;
        end
    end

    // R2: an empty buffer never advances the read pointer
    assert_no_underflow_R2: assert property (@(posedge rd_clk) disable iff (!rst_n)
        !empty_n |=> (rbin == $past(rbin)));
    // R7: without a pop the output register holds
    assert_hold_output_R7: assert property (@(posedge rd_clk) disable iff (!rst_n)
        (!empty_n || rd_en1_n || rd_en2_n) |=> $stable(q));
    // R4: empty always implies almost empty
    assert_empty_in_aempty_R4: assert property (@(posedge rd_clk) disable iff (!rst_n)
        !empty_n |-> !aempty_n);
    // R8: a reset edge leaves the read side empty with a cleared register
    assert_reset_state_R8: assert property (@(posedge rd_clk)
        !rst_n |=> (!empty_n && !aempty_n && (q == '0)));
endmodule

// File: rtl/dcf_fifo.sv
// Top of the dual-clock FIFO: ties storage, both pointer domains and the
// output-enable driver together.
// Assumes: rst_n is held low across several edges of both clocks; offsets
// are quasi-static and smaller than DEPTH.
module dcf_fifo
    import dcf_pkg::*;
#(
    parameter int DATA_W      = DCF_DATA_W_DEF,
    parameter int DEPTH       = DCF_DEPTH_DEF,
    parameter int SYNC_STAGES = DCF_SYNC_DEF
) (
    input  logic                     wr_clk,
    input  logic                     rd_clk,
    input  logic                     rst_n,
    input  logic                     wr_en1_n,
    input  logic                     wr_en2,
    input  logic [DATA_W-1:0]        wr_data,
    input  logic                     rd_en1_n,
    input  logic                     rd_en2_n,
    input  logic                     out_en_n,
    input  logic [$clog2(DEPTH)-1:0] empty_ofs,
    input  logic [$clog2(DEPTH)-1:0] full_ofs,
    output logic [DATA_W-1:0]        rd_data,
    output logic                     empty_n,
    output logic                     aempty_n,
    output logic                     full_n,
    output logic                     afull_n
);
    localparam int ADDR_W = $clog2(DEPTH);

    logic              wr_ok;
    logic [ADDR_W-1:0] waddr, raddr;
    logic [ADDR_W:0]   wgray, rgray;
    logic [DATA_W-1:0] rdata, q;

    dcf_ram #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ram (
        .wr_clk (wr_clk),
        .we     (wr_ok),
        .waddr  (waddr),
        .wdata  (wr_data),
        .raddr  (raddr),
        .rdata  (rdata)
    );

    dcf_wr_ctrl #(.ADDR_W(ADDR_W), .SYNC_STAGES(SYNC_STAGES)) u_wr (
        .wr_clk      (wr_clk),
        .rst_n       (rst_n),
        .wr_en1_n    (wr_en1_n),
        .wr_en2      (wr_en2),
        .full_ofs    (full_ofs),
        .rgray_async (rgray),
        .wr_ok       (wr_ok),
        .waddr       (waddr),
        .wgray       (wgray),
        .full_n      (full_n),
        .afull_n     (afull_n)
    );

    dcf_rd_ctrl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .SYNC_STAGES(SYNC_STAGES)) u_rd (
        .rd_clk      (rd_clk),
        .rst_n       (rst_n),
        .rd_en1_n    (rd_en1_n),
        .rd_en2_n    (rd_en2_n),
        .empty_ofs   (empty_ofs),
        .wgray_async (wgray),
        .rdata       (rdata),
        .raddr       (raddr),
        .rgray       (rgray),
        .q           (q),
        .empty_n     (empty_n),
        .aempty_n    (aempty_n)
    );

    // Drive the bus from the output register or release it.
    assign rd_data = out_en_n ? {DATA_W{1'bz}} : q;
endmodule

// File: tb/dcf_fifo_test.sv
module dcf_fifo_test;
    localparam int DW = 9;
    localparam int DP = 16;
    localparam int AW = 4;

    logic          wr_clk = 0, rd_clk = 0, wr_run = 1, rd_run = 1;
    logic          rst_n = 0, wr_en1_n = 1, wr_en2 = 0, rd_en1_n = 1, rd_en2_n = 1, out_en_n = 0;
    logic [DW-1:0] wr_data = '0;
    logic [AW-1:0] empty_ofs = 4'd3, full_ofs = 4'd2;
    wire  [DW-1:0] rd_data;
    wire           empty_n, aempty_n, full_n, afull_n;

    int checks = 0, failures = 0;
    logic [DW-1:0] model [64];
    int head = 0, tail = 0;
    logic [DW-1:0] last_rd = '0;

    dcf_fifo #(.DATA_W(DW), .DEPTH(DP), .SYNC_STAGES(2)) uut (
        .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n),
        .wr_en1_n(wr_en1_n), .wr_en2(wr_en2), .wr_data(wr_data),
        .rd_en1_n(rd_en1_n), .rd_en2_n(rd_en2_n), .out_en_n(out_en_n),
        .empty_ofs(empty_ofs), .full_ofs(full_ofs), .rd_data(rd_data),
        .empty_n(empty_n), .aempty_n(aempty_n), .full_n(full_n), .afull_n(afull_n)
    );

    // 100 MHz clocks; the read clock is phase shifted and both can be paused.
    initial forever begin #5; if (wr_run) wr_clk = ~wr_clk; end
    initial begin #3; forever begin #5; if (rd_run) rd_clk = ~rd_clk; end end

    initial begin
        #1_000_000;
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic settle();
        repeat (5) @(negedge wr_clk);
        repeat (5) @(negedge rd_clk);
    endtask

    task automatic do_write(input logic [DW-1:0] d, input logic e1n, input logic e2);
        @(negedge wr_clk);
        wr_data = d; wr_en1_n = e1n; wr_en2 = e2;
        @(negedge wr_clk);
        wr_en1_n = 1; wr_en2 = 0;
    endtask

    task automatic push(input logic [DW-1:0] d);
        do_write(d, 1'b0, 1'b1);
        model[tail % 64] = d;
        tail++;
    endtask

    task automatic do_read(input logic e1n, input logic e2n);
        @(negedge rd_clk);
        rd_en1_n = e1n; rd_en2_n = e2n;
        @(negedge rd_clk);
        rd_en1_n = 1; rd_en2_n = 1;
    endtask

    task automatic pop_check(input string req);
        do_read(1'b0, 1'b0);
        last_rd = model[head % 64];
        head++;
        check(req, "popped word", 32'(rd_data), 32'(last_rd));
    endtask

    task automatic t_reset();
        rst_n = 0;
        repeat (6) @(negedge wr_clk);
        repeat (6) @(negedge rd_clk);
        check("R8", "empty_n in reset", 32'(empty_n), 0);
        check("R8", "aempty_n in reset", 32'(aempty_n), 0);
        check("R8", "full_n in reset", 32'(full_n), 1);
        check("R8", "afull_n in reset", 32'(afull_n), 1);
        check("R8", "rd_data in reset", 32'(rd_data), 0);
        @(negedge wr_clk); rst_n = 1;
        head = 0; tail = 0; last_rd = '0;
        settle();
    endtask

    // R3, R9, R2, R7: first word across an empty buffer
    task automatic t_first_word();
        rd_run = 0;
        push(9'h135);
        repeat (6) @(negedge wr_clk);
        check("R3", "empty_n frozen without rd_clk", 32'(empty_n), 0);
        rd_run = 1;
        settle();
        check("R9", "empty_n after first write", 32'(empty_n), 1);
        check("R4", "aempty_n with one word", 32'(aempty_n), 0);
        check("R9", "bus before pop", 32'(rd_data), 0);
        pop_check("R9");
        settle();
        check("R4", "empty_n after drain", 32'(empty_n), 0);
        do_read(1'b0, 1'b0);
        check("R7", "bus holds after read while empty", 32'(rd_data), 32'(last_rd));
        settle();
        check("R2", "empty_n after read while empty", 32'(empty_n), 0);
    endtask

    // R1: writes without both enables are dropped
    task automatic t_write_gating();
        do_write(9'h0F0, 1'b0, 1'b0);
        do_write(9'h0F1, 1'b1, 1'b1);
        settle();
        check("R1", "empty_n after gated writes", 32'(empty_n), 0);
    endtask

    // R4, R5, R1: thresholds and overflow with n=3, m=2
    task automatic t_thresholds();
        for (int i = 0; i < 3; i++) push(9'(9'h040 + i));
        settle();
        check("R4", "aempty_n at n words", 32'(aempty_n), 0);
        check("R4", "empty_n at n words", 32'(empty_n), 1);
        push(9'h043);
        settle();
        check("R4", "aempty_n at n+1 words", 32'(aempty_n), 1);
        for (int i = 0; i < 9; i++) push(9'(9'h050 + i));
        settle();
        check("R5", "afull_n at 13 words", 32'(afull_n), 1);
        push(9'h160);
        settle();
        check("R5", "afull_n at 14 words", 32'(afull_n), 0);
        check("R5", "full_n at 14 words", 32'(full_n), 1);
        push(9'h161);
        push(9'h162);
        check("R5", "full_n at 16 words", 32'(full_n), 0);
        do_write(9'h1AA, 1'b0, 1'b1);
        settle();
        check("R1", "full_n after write while full", 32'(full_n), 0);
    endtask

    // R3, R5: full side flags wait for wr_clk
    task automatic t_full_domain();
        wr_run = 0;
        pop_check("R6");
        repeat (6) @(negedge rd_clk);
        check("R3", "full_n frozen without wr_clk", 32'(full_n), 0);
        wr_run = 1;
        settle();
        check("R5", "full_n at 15 words", 32'(full_n), 1);
        check("R5", "afull_n at 15 words", 32'(afull_n), 0);
    endtask

    // R2, R6, R7, R1: gated reads, full drain, overflow word absent
    task automatic t_drain();
        do_read(1'b0, 1'b1);
        check("R2", "bus after read with rd_en2_n high", 32'(rd_data), 32'(last_rd));
        do_read(1'b1, 1'b0);
        check("R2", "bus after read with rd_en1_n high", 32'(rd_data), 32'(last_rd));
        while (head < tail) pop_check("R6");
        do_read(1'b0, 1'b0);
        check("R7", "bus holds last word", 32'(rd_data), 32'(9'h162));
        settle();
        check("R1", "empty_n after drain (overflow word dropped)", 32'(empty_n), 0);
        check("R4", "aempty_n after drain", 32'(aempty_n), 0);
    endtask

    // R10: output enable
    task automatic t_output_enable();
        @(negedge rd_clk); out_en_n = 1;
        #1;
        check("R10", "bus released", 32'(rd_data), 32'(9'bz_zzzz_zzzz));
        out_en_n = 0;
        #1;
        check("R10", "bus driven", 32'(rd_data), 32'(9'h162));
    endtask

    // R8: reset with data inside
    task automatic t_reset_midstream();
        push(9'h011);
        push(9'h022);
        settle();
        check("R8", "empty_n before reset", 32'(empty_n), 1);
        t_reset();
        push(9'h077);
        settle();
        pop_check("R6");
    endtask

    initial begin
        t_reset();
        t_first_word();
        t_write_gating();
        t_thresholds();
        t_full_domain();
        t_drain();
        t_output_enable();
        t_reset_midstream();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule